// File: doc/BRIEF.md
# Two-Thread Split Reorder Buffer

This block tracks in-flight micro-ops for two hardware threads in program order. Its storage is divided into two equal, fixed regions, one per thread. Each region is run as a private ring with its own head, tail and occupancy. Each entry stands for a single micro-op and holds one completion flag.

In any cycle the front end may present a group of one to `Group` micro-ops for a single thread, chosen by a thread-select input. The whole group is taken only when the thread's region has room for all of it. Otherwise that thread's stall output rises and nothing is written.

Every accepted micro-op gets a tag made of the thread bit and the index of the micro-op inside its region. Execution units return these tags on the completion ports. Each thread retires up to `Retire` completed entries per cycle, oldest first. A per-thread flush empties one region in a single cycle and leaves the other region alone.

Top module: `split_rob`

## Requirements
- R1: The capacity `Entries` (default 192, even) is split into two regions of `Entries/2` entries. A thread never holds more than `Entries/2` live entries. A tag's most significant bit is the thread id, and its low bits are an index below `Entries/2`.
- R2: When a group is accepted, `allocTags[k]` for k below `allocCount` holds the thread id and the region index `(tail + k) mod (Entries/2)`. The tags are consecutive and begin at the thread's current tail. Only the thread named by `allocTid` is affected.
- R3: A request with `allocCount` from 1 to `Group` is accepted (`allocAccept` high) only if the thread's free entries are at least `allocCount`. If not, `allocStall` for that thread is high, and neither pointers nor occupancy change. Stall and accept are never high together.
- R4: `threadFull[t]` is high exactly when thread t holds `Entries/2` live entries.
- R5: A completion tag sets the done flag of its entry. That entry can retire no earlier than the cycle after the completion is presented.
- R6: `retireCnt[t]` is the number of consecutive done entries starting at the thread's head, capped at `Retire` and at the live count. Counting stops at the first entry that is not done. The head then advances by that amount.
- R7: A flush of thread t forces `retireCnt[t]` to 0 and blocks any allocation for t in that cycle. It leaves thread t empty in the next cycle, with head and tail at index 0. The other thread keeps its state and its retire count.
- R8: Head and tail advance modulo `Entries/2` inside their own region. `retireHead[t]` gives the region index of the oldest live entry of thread t.
- R9: After reset both regions are empty: no full flag, no retirement, and the first accepted group of each thread starts at index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| allocValid | input | 1 | Allocation request present |
| allocTid | input | 1 | Thread making the request |
| allocCount | input | $clog2(Group+1) | Micro-ops in the group, 1..Group |
| allocAccept | output | 1 | Group written this cycle |
| allocStall | output | 2 | Per-thread lack of room for the requested group |
| allocTags | output | Group x ($clog2(Entries/2)+1) | Tags for the group's slots |
| threadFull | output | 2 | Per-thread region full |
| compValid | input | CplPorts | Completion strobes |
| compTag | input | CplPorts x ($clog2(Entries/2)+1) | Completion tags |
| flush | input | 2 | Per-thread flush |
| retireCnt | output | 2 x $clog2(Retire+1) | Entries retired per thread this cycle |
| retireHead | output | 2 x $clog2(Entries/2) | Region index of each thread's oldest entry |

## Verification
The assertions assume the following about the inputs. `allocCount` stays between 1 and `Group` while `allocValid` is high. A completion tag names an entry that is live in its thread's region. The stimulus meets both conditions because every request draws its size from that range, and every completion is picked from the reference model's list of live entries for a non-empty thread. Flushes and allocations to the same thread are allowed to coincide, because the block defines who wins in that case.

// File: rtl/rob_pkg.sv
package rob_pkg;
  localparam int NumThreads = 2;

  // Per-thread strobes issued by control to the entry store
  typedef struct packed {
    logic [NumThreads-1:0] alloc;
    logic [NumThreads-1:0] flush;
  } robStrobe_t;
endpackage

// File: rtl/rob_ctrl.sv
module rob_ctrl
  import rob_pkg::*;
#(
  parameter int Entries = 192,
  parameter int Group   = 4,
  parameter int Retire  = 4,
  localparam int Half   = Entries / 2,
  localparam int IdxW   = $clog2(Half),
  localparam int CntW   = $clog2(Half + 1),
  localparam int GrpW   = $clog2(Group + 1),
  localparam int RetW   = $clog2(Retire + 1),
  localparam int TagW   = IdxW + 1
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           allocValid,
  input  logic                           allocTid,
  input  logic [GrpW-1:0]                allocCount,
  input  logic [1:0]                     flush,
  input  logic [1:0][Retire-1:0]         doneWin,
  output robStrobe_t                     strobe,
  output logic [1:0][IdxW-1:0]           headIdx,
  output logic [1:0][IdxW-1:0]           tailIdx,
  output logic [1:0][CntW-1:0]           liveCnt,
  output logic [1:0][RetW-1:0]           retireCnt,
  output logic [1:0]                     allocStall,
  output logic                           allocAccept,
  output logic [1:0]                     threadFull,
  output logic [Group-1:0][TagW-1:0]     allocTags
);

  function automatic logic [IdxW-1:0] wrapAdd(input logic [IdxW-1:0] base,
                                              input int unsigned step);
    int unsigned sum;
    sum = int'(base) + step;
    if (sum >= Half) sum = sum - Half;
    return sum[IdxW-1:0];
  endfunction

  logic [1:0] accVec;
  logic       sizeOk;

  assign sizeOk = (allocCount != '0) && (int'(allocCount) <= Group);

  for (genvar t = 0; t < 2; t++) begin : gThread
    logic [IdxW-1:0] headQ, tailQ;
    logic [CntW-1:0] cntQ, freeSlots;
    logic            sel, acc, room;
    logic [RetW-1:0] ret;
    logic            run;

    assign freeSlots = CntW'(Half) - cntQ;
    assign sel  = allocValid && (allocTid == 1'(t)) && !flush[t];
    assign room = CntW'(allocCount) <= freeSlots;
    assign acc  = sel && sizeOk && room;

    always_comb begin
      run = 1'b1;
      ret = '0;
      for (int k = 0; k < Retire; k++) begin
        if (run && doneWin[t][k] && (k < int'(cntQ))) ret = RetW'(k + 1);
        else run = 1'b0;
      end
      if (flush[t]) ret = '0;
    end

    always_ff @(posedge clk) begin
      if (!rstN || flush[t]) begin
        headQ <= '0;
        tailQ <= '0;
        cntQ  <= '0;
      end else begin
        headQ <= wrapAdd(headQ, int'(ret));
        if (acc) tailQ <= wrapAdd(tailQ, int'(allocCount));
        cntQ <= cntQ + (acc ? CntW'(allocCount) : CntW'(0)) - CntW'(ret);
      end
    end

    assign accVec[t]     = acc;
    assign allocStall[t] = sel && sizeOk && !room;
    assign threadFull[t] = (cntQ == CntW'(Half));
    assign headIdx[t]    = headQ;
    assign tailIdx[t]    = tailQ;
    assign liveCnt[t]    = cntQ;
    assign retireCnt[t]  = ret;
  end

  always_comb begin
    for (int k = 0; k < Group; k++) begin
      allocTags[k] = {allocTid, wrapAdd(tailIdx[allocTid], k)};
    end
  end

  assign allocAccept = |accVec;
  assign strobe      = '{alloc: accVec, flush: flush};

endmodule

// File: rtl/rob_store.sv
module rob_store
  import rob_pkg::*;
#(
  parameter int Entries  = 192,
  parameter int Group    = 4,
  parameter int Retire   = 4,
  parameter int CplPorts = 2,
  localparam int Half    = Entries / 2,
  localparam int IdxW    = $clog2(Half),
  localparam int GrpW    = $clog2(Group + 1),
  localparam int TagW    = IdxW + 1
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  robStrobe_t                     strobe,
  input  logic [GrpW-1:0]                allocCount,
  input  logic [1:0][IdxW-1:0]           headIdx,
  input  logic [1:0][IdxW-1:0]           tailIdx,
  input  logic [CplPorts-1:0]            compValid,
  input  logic [CplPorts-1:0][TagW-1:0]  compTag,
  output logic [1:0][Retire-1:0]         doneWin
);

  function automatic int slotOf(input int thread, input logic [IdxW-1:0] base,
                                input int unsigned step);
    int unsigned idx;
    idx = int'(base) + step;
    if (idx >= Half) idx = idx - Half;
    return thread * Half + int'(idx);
  endfunction

  logic [Entries-1:0] done, doneNext;

  always_comb begin
    doneNext = done;
    for (int p = 0; p < CplPorts; p++) begin
      if (compValid[p])
        doneNext[slotOf(int'(compTag[p][TagW-1]), compTag[p][IdxW-1:0], 0)] = 1'b1;
    end
    // a fresh allocation always starts not-done, overriding any stale completion
    for (int t = 0; t < 2; t++) begin
      for (int k = 0; k < Group; k++) begin
        if (strobe.alloc[t] && (k < int'(allocCount)))
          doneNext[slotOf(t, tailIdx[t], k)] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) done <= '0;
    else       done <= doneNext;
  end

  always_comb begin
    for (int t = 0; t < 2; t++) begin
      for (int k = 0; k < Retire; k++) begin
        doneWin[t][k] = done[slotOf(t, headIdx[t], k)];
      end
    end
  end

endmodule

// File: rtl/split_rob.sv
module split_rob
  import rob_pkg::*;
#(
  parameter int Entries  = 192,
  parameter int Group    = 4,
  parameter int Retire   = 4,
  parameter int CplPorts = 2,
  localparam int Half    = Entries / 2,
  localparam int IdxW    = $clog2(Half),
  localparam int CntW    = $clog2(Half + 1),
  localparam int GrpW    = $clog2(Group + 1),
  localparam int RetW    = $clog2(Retire + 1),
  localparam int TagW    = IdxW + 1
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           allocValid,
  input  logic                           allocTid,
  input  logic [GrpW-1:0]                allocCount,
  output logic                           allocAccept,
  output logic [1:0]                     allocStall,
  output logic [Group-1:0][TagW-1:0]     allocTags,
  output logic [1:0]                     threadFull,
  input  logic [CplPorts-1:0]            compValid,
  input  logic [CplPorts-1:0][TagW-1:0]  compTag,
  input  logic [1:0]                     flush,
  output logic [1:0][RetW-1:0]           retireCnt,
  output logic [1:0][IdxW-1:0]           retireHead
);

  robStrobe_t              strobe;
  logic [1:0][IdxW-1:0]    headIdx, tailIdx;
  logic [1:0][CntW-1:0]    threadCount;
  logic [1:0][Retire-1:0]  doneWin;

  rob_ctrl #(.Entries(Entries), .Group(Group), .Retire(Retire)) u_ctrl (
    .clk(clk), .rstN(rstN), .allocValid(allocValid), .allocTid(allocTid),
    .allocCount(allocCount), .flush(flush), .doneWin(doneWin), .strobe(strobe),
    .headIdx(headIdx), .tailIdx(tailIdx), .liveCnt(threadCount),
    .retireCnt(retireCnt), .allocStall(allocStall), .allocAccept(allocAccept),
    .threadFull(threadFull), .allocTags(allocTags)
  );

  rob_store #(.Entries(Entries), .Group(Group), .Retire(Retire), .CplPorts(CplPorts)) u_store (
    .clk(clk), .rstN(rstN), .strobe(strobe), .allocCount(allocCount),
    .headIdx(headIdx), .tailIdx(tailIdx), .compValid(compValid),
    .compTag(compTag), .doneWin(doneWin)
  );

  assign retireHead = headIdx;

endmodule

// File: rtl/split_rob_checker.sv
module split_rob_checker #(
  parameter int Half  = 96,
  parameter int Group = 4,
  parameter int CntW  = 7,
  parameter int GrpW  = 3,
  parameter int RetW  = 3
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   allocValid,
  input logic                   allocTid,
  input logic [GrpW-1:0]        allocCount,
  input logic                   allocAccept,
  input logic [1:0]             allocStall,
  input logic [1:0]             threadFull,
  input logic [1:0]             flush,
  input logic [1:0][RetW-1:0]   retireCnt,
  input logic [1:0][CntW-1:0]   threadCount
);

  assert_stall_accept_excl_R3: assert property (@(posedge clk) disable iff (!rstN)
    allocAccept |-> (allocStall == 2'b00));

  for (genvar t = 0; t < 2; t++) begin : gChk
    localparam int O = 1 - t;

    assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rstN)
      int'(threadCount[t]) <= Half);

    assert_stall_owner_R3: assert property (@(posedge clk) disable iff (!rstN)
      allocStall[t] |-> (allocValid && allocTid == 1'(t) && !flush[t]));

    assert_full_blocks_R4: assert property (@(posedge clk) disable iff (!rstN)
      (threadFull[t] && allocValid && allocTid == 1'(t) && !flush[t] &&
       allocCount != '0 && int'(allocCount) <= Group) |-> allocStall[t]);

    assert_retire_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
      retireCnt[t] <= RetW'(threadCount[t]) || int'(threadCount[t]) >= (1 << RetW));

    assert_flush_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
      flush[t] |-> (retireCnt[t] == '0));

    assert_flush_empty_R7: assert property (@(posedge clk) disable iff (!rstN)
      flush[t] |=> (threadCount[t] == '0 && !threadFull[t]));

    assert_flush_isolate_R7: assert property (@(posedge clk) disable iff (!rstN)
      (flush[t] && !flush[O] && !(allocAccept && allocTid == 1'(O)) && retireCnt[O] == '0)
        |=> $stable(threadCount[O]));
  end

endmodule

bind split_rob split_rob_checker #(
  .Half(Entries / 2), .Group(Group), .CntW($clog2(Entries / 2 + 1)),
  .GrpW($clog2(Group + 1)), .RetW($clog2(Retire + 1))
) u_chk (
  .clk(clk), .rstN(rstN), .allocValid(allocValid), .allocTid(allocTid),
  .allocCount(allocCount), .allocAccept(allocAccept), .allocStall(allocStall),
  .threadFull(threadFull), .flush(flush), .retireCnt(retireCnt),
  .threadCount(threadCount)
);

// File: tb/split_rob_bench.sv
module split_rob_bench;
  localparam int HALF = 96;
  localparam int IDXW = 7;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic allocValid = 1'b0;
  logic allocTid = 1'b0;
  logic [2:0] allocCount = 3'd0;
  logic allocAccept;
  logic [1:0] allocStall;
  logic [3:0][7:0] allocTags;
  logic [1:0] threadFull;
  logic [1:0] compValid = 2'b00;
  logic [1:0][7:0] compTag = '0;
  logic [1:0] flush = 2'b00;
  logic [1:0][2:0] retireCnt;
  logic [1:0][6:0] retireHead;

  always #2 clk = ~clk;

  split_rob u_split_rob (
    .clk(clk), .rstN(rstN), .allocValid(allocValid), .allocTid(allocTid),
    .allocCount(allocCount), .allocAccept(allocAccept), .allocStall(allocStall),
    .allocTags(allocTags), .threadFull(threadFull), .compValid(compValid),
    .compTag(compTag), .flush(flush), .retireCnt(retireCnt), .retireHead(retireHead)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  int mHead[2];
  int mTail[2];
  int mCnt[2];
  bit mDone[2][HALF];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic pickCompletion(input int p, input int phase2);
    int t, off;
    compValid[p] = 1'b0;
    t = (phase2 != 0) ? 0 : $urandom_range(1, 0);
    if (mCnt[t] == 0) t = 1 - t;
    if (mCnt[t] == 0) return;
    if (phase2 == 1 && mCnt[t] > 1) off = $urandom_range(mCnt[t] - 1, 1);
    else off = $urandom_range(mCnt[t] - 1, 0);
    compValid[p] = 1'b1;
    compTag[p] = 8'((t << IDXW) | ((mHead[t] + off) % HALF));
  endtask

  initial begin : main
    for (int t = 0; t < 2; t++) begin
      mHead[t] = 0; mTail[t] = 0; mCnt[t] = 0;
      for (int i = 0; i < HALF; i++) mDone[t][i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    // R9 reset state
    check(allocAccept == 1'b0, "R9", "accept after reset", int'(allocAccept), 0);
    check(threadFull == 2'b00, "R9", "full after reset", int'(threadFull), 0);
    check(retireCnt == '0, "R9", "retire after reset", int'(retireCnt), 0);
    check(allocStall == 2'b00, "R9", "stall after reset", int'(allocStall), 0);

    for (int cyc = 0; cyc < 3000; cyc++) begin
      int ph;
      @(negedge clk);
      ph = (cyc < 60) ? 0 : (cyc < 100) ? 1 : (cyc < 160) ? 2 : 3;
      // drive stimulus
      flush = 2'b00;
      if (ph == 0) begin
        allocValid = 1'b1; allocTid = 1'b0; allocCount = 3'($urandom_range(4, 1));
        compValid = 2'b00;
      end else if (ph == 1 || ph == 2) begin
        allocValid = 1'b0; allocCount = 3'd1;
        for (int p = 0; p < 2; p++) pickCompletion(p, ph);
      end else begin
        allocValid = ($urandom_range(9, 0) < 7);
        allocTid = 1'($urandom_range(1, 0));
        allocCount = 3'($urandom_range(4, 1));
        for (int p = 0; p < 2; p++)
          if ($urandom_range(9, 0) < 6) pickCompletion(p, 0); else compValid[p] = 1'b0;
        for (int t = 0; t < 2; t++) flush[t] = ($urandom_range(99, 0) < 2);
      end
      #1;
      begin
        int expRet[2];
        bit expAcc[2];
        bit sel;
        bit anyAcc;
        anyAcc = 0;
        for (int t = 0; t < 2; t++) begin
          string rreq;
          sel = allocValid && (int'(allocTid) == t) && !flush[t];
          expAcc[t] = sel && (int'(allocCount) <= HALF - mCnt[t]);
          anyAcc |= expAcc[t];
          expRet[t] = 0;
          if (!flush[t])
            while (expRet[t] < 4 && expRet[t] < mCnt[t] &&
                   mDone[t][(mHead[t] + expRet[t]) % HALF]) expRet[t]++;
          rreq = flush[t] ? "R7" : (ph == 1 || ph == 2) ? "R5" : "R6";
          check(int'(retireCnt[t]) == expRet[t], rreq, $sformatf("retireCnt[%0d]", t),
                int'(retireCnt[t]), expRet[t]);
          check(allocStall[t] == (sel && !expAcc[t]), "R3", $sformatf("allocStall[%0d]", t),
                int'(allocStall[t]), int'(sel && !expAcc[t]));
          check(threadFull[t] == (mCnt[t] == HALF), "R4", $sformatf("threadFull[%0d]", t),
                int'(threadFull[t]), int'(mCnt[t] == HALF));
          if (mCnt[t] > 0)
            check(int'(retireHead[t]) == mHead[t], "R8", $sformatf("retireHead[%0d]", t),
                  int'(retireHead[t]), mHead[t]);
        end
        check(allocAccept == anyAcc, "R3", "allocAccept", int'(allocAccept), int'(anyAcc));
        if (anyAcc) begin
          int t;
          t = int'(allocTid);
          for (int k = 0; k < int'(allocCount); k++) begin
            int expTag;
            expTag = (t << IDXW) | ((mTail[t] + k) % HALF);
            check(int'(allocTags[k][7]) == t, "R1", "tag thread bit",
                  int'(allocTags[k][7]), t);
            check(int'(allocTags[k]) == expTag, "R2", $sformatf("allocTags[%0d]", k),
                  int'(allocTags[k]), expTag);
          end
        end
        // advance model to the coming edge
        for (int p = 0; p < 2; p++)
          if (compValid[p]) mDone[int'(compTag[p][7])][int'(compTag[p][6:0])] = 1;
        for (int t = 0; t < 2; t++) begin
          if (flush[t]) begin
            mHead[t] = 0; mTail[t] = 0; mCnt[t] = 0;
          end else begin
            mHead[t] = (mHead[t] + expRet[t]) % HALF;
            if (expAcc[t]) begin
              for (int k = 0; k < int'(allocCount); k++) mDone[t][(mTail[t] + k) % HALF] = 0;
              mTail[t] = (mTail[t] + int'(allocCount)) % HALF;
            end
            mCnt[t] = mCnt[t] + (expAcc[t] ? int'(allocCount) : 0) - expRet[t];
          end
        end
      end
    end
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : watchdog
    #(200000 * 4);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog run did not end actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule